// File: doc/BRIEF.md
# Synchronous Dual-Port RAM with Power-Down and Sleep

This block is a small, parameterized synchronous RAM with two fully independent ports, A and B. Each port registers its address, write data, write strobe, chip-enable pair, counter controls and sleep input on the rising clock edge. The port then acts on these registered values at the next edge. A read returns its data one cycle after the request is registered, together with a valid flag. Each port carries its own address counter. The counter can be loaded from the address bus, advanced by one with wrap-around, or held still. This makes burst and interleaved accesses cheap for the client.

Each port has a per-port control state machine with five states. PS_RUN is normal operation. PS_DOWN is powered down by the chip-enable pair. PS_WAKE means the first of two selected wake-up cycles has been seen. PS_SLEEP is entered while the sleep input is high. PS_REARM follows sleep and waits for one full selected cycle. The transitions are:
- RUN to DOWN on the power-down pattern.
- DOWN to WAKE on a selected cycle.
- WAKE to RUN on a second selected cycle, which may already access the array.
- WAKE to DOWN on any other pattern.
- SLEEP to REARM once sleep is sampled low.
- REARM to RUN on a selected cycle, or to DOWN on the power-down pattern.
- Any state to SLEEP while sleep is sampled high.

The array is touched only in RUN, or in WAKE on the second wake-up cycle. The data outputs are modelled as high-impedance plus an explicit drive flag. They are gated at once by the output enable and the sleep input.

Top module: `syncdp_ram`

## Requirements
- R1: Inputs are registered at a rising edge and acted on at the next edge. A read with chip-enable selected (x_ce0_n=0, x_ce1=1, x_we=0) drives x_dvld=1 with the word, and x_dvld is 1 only in the cycle after such an access.
- R2: x_oe_n=1 forces x_drv=0 and x_dout to high-impedance immediately, without a clock edge; x_dvld is unaffected by it.
- R3: The effective address is chosen as follows. If x_ld=1, the address bus is used and loaded into the counter. Otherwise, if x_cnt_en=1, the counter plus one is used (DEPTH-1 wraps to 0). Otherwise the held counter value is used. The counter moves only on cycles that access the array.
- R4: Sampling x_ce0_n=1 with x_ce1=0 powers the port down. Any access in that cycle, or in later cycles until wake-up completes, is dropped, including writes.
- R5: After power-down, two consecutive selected cycles are needed. The first performs no access and gives no data. The second performs its access and gives valid data one cycle later.
- R6: While x_zz=1 the port drives nothing (x_drv=0, x_dvld=0 immediately), and no read or write is performed.
- R7: After x_zz falls, the first cycle performs no access. One further selected cycle must then pass without access before a read returns data.
- R8: When both ports write the same address in the same cycle, port A's data is stored and coll is 1 for exactly the following cycle. Writes to different addresses do not raise coll.
- R9: A read on one port of an address the other port writes in the same cycle returns the old contents.
- R10: After reset, both ports are in normal operation with x_dvld=0, x_drv=0 and coll=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_addr | input | AW | Port A address / counter load value |
| a_din | input | DW | Port A write data |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_ce0_n | input | 1 | Port A chip enable, active low |
| a_ce1 | input | 1 | Port A chip enable, active high |
| a_ld | input | 1 | Port A counter load |
| a_cnt_en | input | 1 | Port A counter advance |
| a_oe_n | input | 1 | Port A output enable, active low, asynchronous |
| a_zz | input | 1 | Port A sleep, active high |
| a_dout | output | DW | Port A read data, high-impedance when not driven |
| a_drv | output | 1 | Port A data outputs are driving |
| a_dvld | output | 1 | Port A read data valid |
| b_addr | input | AW | Port B address / counter load value |
| b_din | input | DW | Port B write data |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_ce0_n | input | 1 | Port B chip enable, active low |
| b_ce1 | input | 1 | Port B chip enable, active high |
| b_ld | input | 1 | Port B counter load |
| b_cnt_en | input | 1 | Port B counter advance |
| b_oe_n | input | 1 | Port B output enable, active low, asynchronous |
| b_zz | input | 1 | Port B sleep, active high |
| b_dout | output | DW | Port B read data, high-impedance when not driven |
| b_drv | output | 1 | Port B data outputs are driving |
| b_dvld | output | 1 | Port B read data valid |
| coll | output | 1 | Same-address write collision pulse |

## Verification
A port state machine stuck in, or wrongly leaving, DOWN, WAKE, SLEEP or REARM shows up at the ports as a valid flag that is missing, or that appears when it should not. This is visible in the second cycle after the selecting request. A dropped or spurious write shows up only later, when the address is read back. For that reason, every ignored-write case is followed by a read of the same address. A counter that moves on a non-access cycle, or that fails to wrap, returns the word of a neighbouring address on the next counted read. The sweeps therefore use distinct contents per address, so that any such slip is caught.

// File: rtl/sdpr_pkg.sv
package sdpr_pkg;

    typedef enum logic [2:0] {
        PS_RUN   = 3'd0,
        PS_DOWN  = 3'd1,
        PS_WAKE  = 3'd2,
        PS_SLEEP = 3'd3,
        PS_REARM = 3'd4
    } port_state_e;

endpackage

// File: rtl/sdpr_addr_cnt.sv
module sdpr_addr_cnt #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          ld,
    input  logic          inc,
    input  logic [AW-1:0] ld_val,
    output logic [AW-1:0] eff_addr
);
    localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

    logic [AW-1:0] cnt_q;
    logic [AW-1:0] cnt_plus;

    always_comb begin
        cnt_plus = (cnt_q == TOP) ? '0 : cnt_q + 1'b1;
        if (ld) begin
            eff_addr = ld_val;
        end else if (inc) begin
            eff_addr = cnt_plus;
        end else begin
            eff_addr = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= eff_addr;
        end
    end

endmodule

// File: rtl/sdpr_port_ctl.sv
module sdpr_port_ctl
    import sdpr_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    input  logic          we,
    input  logic          ce0_n,
    input  logic          ce1,
    input  logic          ld,
    input  logic          cnt_en,
    input  logic          zz,
    output logic          acc_o,
    output logic          wr_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] din_o
);
    logic [AW-1:0] addr_q;
    logic [DW-1:0] din_q;
    logic          we_q, ce0_n_q, ce1_q, ld_q, cnt_en_q, zz_q;
    logic          sel, pdn;

    port_state_e st_q, st_d;

    // input capture stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            din_q    <= '0;
            we_q     <= 1'b0;
            ce0_n_q  <= 1'b1;
            ce1_q    <= 1'b1;
            ld_q     <= 1'b0;
            cnt_en_q <= 1'b0;
            zz_q     <= 1'b0;
        end else begin
            addr_q   <= addr;
            din_q    <= din;
            we_q     <= we;
            ce0_n_q  <= ce0_n;
            ce1_q    <= ce1;
            ld_q     <= ld;
            cnt_en_q <= cnt_en;
            zz_q     <= zz;
        end
    end

    assign sel = !ce0_n_q && ce1_q;
    assign pdn = ce0_n_q && !ce1_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= PS_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PS_RUN:   if (pdn) st_d = PS_DOWN;
            PS_DOWN:  if (sel) st_d = PS_WAKE;
            PS_WAKE:  st_d = sel ? PS_RUN : PS_DOWN;
            PS_SLEEP: st_d = PS_REARM;
            PS_REARM: begin
                if (sel) begin
                    st_d = PS_RUN;
                end else if (pdn) begin
                    st_d = PS_DOWN;
                end
            end
            default:  st_d = PS_DOWN;
        endcase
        if (zz_q) begin
            st_d = PS_SLEEP;
        end
    end

    // outputs: which cycles may touch the array
    always_comb begin
        acc_o = 1'b0;
        unique case (st_q)
            PS_RUN:   acc_o = sel;
            PS_WAKE:  acc_o = sel;
            PS_DOWN:  acc_o = 1'b0;
            PS_SLEEP: acc_o = 1'b0;
            PS_REARM: acc_o = 1'b0;
            default:  acc_o = 1'b0;
        endcase
        if (zz_q) begin
            acc_o = 1'b0;
        end
    end

    assign wr_o  = we_q;
    assign din_o = din_q;

    sdpr_addr_cnt #(.DEPTH(DEPTH), .AW(AW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (acc_o),
        .ld       (ld_q),
        .inc      (cnt_en_q),
        .ld_val   (addr_q),
        .eff_addr (addr_o)
    );

endmodule

// File: rtl/sdpr_array.sv
module sdpr_array #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int AW    = $clog2(DEPTH),
    parameter int NP    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc   [NP],
    input  logic          wr    [NP],
    input  logic [AW-1:0] addr  [NP],
    input  logic [DW-1:0] din   [NP],
    output logic [DW-1:0] rdata [NP],
    output logic          rvld  [NP],
    output logic          coll
);
    logic [DW-1:0] mem [DEPTH];

    // higher port index written first so port 0 (A) wins a same-address tie
    always_ff @(posedge clk) begin
        for (int p = NP - 1; p >= 0; p--) begin
            if (acc[p] && wr[p]) begin
                mem[addr[p]] <= din[p];
            end
        end
    end

    for (genvar g = 0; g < NP; g++) begin : g_rd
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rdata[g] <= '0;
                rvld[g]  <= 1'b0;
            end else begin
                rvld[g] <= acc[g] && !wr[g];
                if (acc[g] && !wr[g]) begin
                    rdata[g] <= mem[addr[g]];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            coll <= 1'b0;
        end else begin
            coll <= acc[0] && wr[0] && acc[1] && wr[1] && (addr[0] == addr[1]);
        end
    end

endmodule

// File: rtl/syncdp_ram.sv
module syncdp_ram #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_din,
    input  logic          a_we,
    input  logic          a_ce0_n,
    input  logic          a_ce1,
    input  logic          a_ld,
    input  logic          a_cnt_en,
    input  logic          a_oe_n,
    input  logic          a_zz,
    output logic [DW-1:0] a_dout,
    output logic          a_drv,
    output logic          a_dvld,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_din,
    input  logic          b_we,
    input  logic          b_ce0_n,
    input  logic          b_ce1,
    input  logic          b_ld,
    input  logic          b_cnt_en,
    input  logic          b_oe_n,
    input  logic          b_zz,
    output logic [DW-1:0] b_dout,
    output logic          b_drv,
    output logic          b_dvld,
    output logic          coll
);
    localparam int NP = 2;

    logic          acc   [NP];
    logic          wr    [NP];
    logic [AW-1:0] eaddr [NP];
    logic [DW-1:0] wdat  [NP];
    logic [DW-1:0] rdata [NP];
    logic          rvld  [NP];

    sdpr_port_ctl #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_ctl_a (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (a_addr),
        .din    (a_din),
        .we     (a_we),
        .ce0_n  (a_ce0_n),
        .ce1    (a_ce1),
        .ld     (a_ld),
        .cnt_en (a_cnt_en),
        .zz     (a_zz),
        .acc_o  (acc[0]),
        .wr_o   (wr[0]),
        .addr_o (eaddr[0]),
        .din_o  (wdat[0])
    );

    sdpr_port_ctl #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_ctl_b (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (b_addr),
        .din    (b_din),
        .we     (b_we),
        .ce0_n  (b_ce0_n),
        .ce1    (b_ce1),
        .ld     (b_ld),
        .cnt_en (b_cnt_en),
        .zz     (b_zz),
        .acc_o  (acc[1]),
        .wr_o   (wr[1]),
        .addr_o (eaddr[1]),
        .din_o  (wdat[1])
    );

    sdpr_array #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .NP(NP)) u_arr (
        .clk   (clk),
        .rst_n (rst_n),
        .acc   (acc),
        .wr    (wr),
        .addr  (eaddr),
        .din   (wdat),
        .rdata (rdata),
        .rvld  (rvld),
        .coll  (coll)
    );

    // sleep and output enable act without waiting for a clock edge
    assign a_dvld = rvld[0] && !a_zz;
    assign b_dvld = rvld[1] && !b_zz;
    assign a_drv  = a_dvld && !a_oe_n;
    assign b_drv  = b_dvld && !b_oe_n;
    assign a_dout = a_drv ? rdata[0] : {DW{1'bz}};
    assign b_dout = b_drv ? rdata[1] : {DW{1'bz}};

endmodule

// File: rtl/sdpr_chk.sv
module sdpr_chk (
    input logic clk,
    input logic rst_n,
    input logic a_we,
    input logic a_ce0_n,
    input logic a_ce1,
    input logic a_oe_n,
    input logic a_zz,
    input logic a_drv,
    input logic a_dvld,
    input logic b_we,
    input logic b_ce0_n,
    input logic b_ce1,
    input logic b_oe_n,
    input logic b_zz,
    input logic b_drv,
    input logic b_dvld,
    input logic coll
);
    // R1: valid data only two edges after a selected read request
    p_rd_src_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
        a_dvld |-> (!$past(a_ce0_n, 2) && $past(a_ce1, 2) && !$past(a_we, 2)));
    p_rd_src_b_r1: assert property (@(posedge clk) disable iff (!rst_n)
        b_dvld |-> (!$past(b_ce0_n, 2) && $past(b_ce1, 2) && !$past(b_we, 2)));

    // R4: a power-down sample never yields data
    p_pd_blank_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(a_ce0_n, 2) && !$past(a_ce1, 2)) |-> !a_dvld);
    p_pd_blank_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(b_ce0_n, 2) && !$past(b_ce1, 2)) |-> !b_dvld);

    // R6: a sampled sleep request blocks the following read result
    p_sleep_blank_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(a_zz, 2) |-> !a_dvld);
    p_sleep_blank_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(b_zz, 2) |-> !b_dvld);

    // R8: a collision needs two writes two edges back
    p_coll_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        coll |-> ($past(a_we, 2) && $past(b_we, 2)));

    // R2 and R6: asynchronous output gating
    always @(negedge clk) begin
        if (rst_n) begin
            p_oe_float_r2: assert (!((a_oe_n && a_drv) || (b_oe_n && b_drv)));
            p_zz_float_r6: assert (!((a_zz && (a_drv || a_dvld)) || (b_zz && (b_drv || b_dvld))));
        end
    end

endmodule

bind syncdp_ram sdpr_chk u_sdpr_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_we    (a_we),
    .a_ce0_n (a_ce0_n),
    .a_ce1   (a_ce1),
    .a_oe_n  (a_oe_n),
    .a_zz    (a_zz),
    .a_drv   (a_drv),
    .a_dvld  (a_dvld),
    .b_we    (b_we),
    .b_ce0_n (b_ce0_n),
    .b_ce1   (b_ce1),
    .b_oe_n  (b_oe_n),
    .b_zz    (b_zz),
    .b_drv   (b_drv),
    .b_dvld  (b_dvld),
    .coll    (coll)
);

// File: tb/syncdp_ram_tb_top.sv
module syncdp_ram_tb_top;
    localparam int DEPTH = 16;
    localparam int DW    = 8;
    localparam int AW    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [DW-1:0] a_din = '0, b_din = '0;
    logic a_we = 0, a_ce0_n = 1, a_ce1 = 1, a_ld = 0, a_cnt_en = 0, a_oe_n = 0, a_zz = 0;
    logic b_we = 0, b_ce0_n = 1, b_ce1 = 1, b_ld = 0, b_cnt_en = 0, b_oe_n = 0, b_zz = 0;
    wire  [DW-1:0] a_dout, b_dout;
    logic a_drv, a_dvld, b_drv, b_dvld, coll;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [DW-1:0] ref_mem [DEPTH];

    always #10 clk = ~clk;

    syncdp_ram #(.DEPTH(DEPTH), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_addr(a_addr), .a_din(a_din), .a_we(a_we), .a_ce0_n(a_ce0_n), .a_ce1(a_ce1),
        .a_ld(a_ld), .a_cnt_en(a_cnt_en), .a_oe_n(a_oe_n), .a_zz(a_zz),
        .a_dout(a_dout), .a_drv(a_drv), .a_dvld(a_dvld),
        .b_addr(b_addr), .b_din(b_din), .b_we(b_we), .b_ce0_n(b_ce0_n), .b_ce1(b_ce1),
        .b_ld(b_ld), .b_cnt_en(b_cnt_en), .b_oe_n(b_oe_n), .b_zz(b_zz),
        .b_dout(b_dout), .b_drv(b_drv), .b_dvld(b_dvld),
        .coll(coll)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic drv(input int p, input logic c0n, input logic c1, input logic w,
                       input logic l, input logic i, input logic [AW-1:0] ad, input logic [DW-1:0] d);
        if (p == 0) begin
            a_ce0_n = c0n; a_ce1 = c1; a_we = w; a_ld = l; a_cnt_en = i; a_addr = ad; a_din = d;
        end else begin
            b_ce0_n = c0n; b_ce1 = c1; b_we = w; b_ld = l; b_cnt_en = i; b_addr = ad; b_din = d;
        end
    endtask

    task automatic idl(input int p);
        drv(p, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0, '0);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // selected access, then idle, sample point two negedges later
    task automatic op(input int p, input logic w, input logic l, input logic i,
                      input logic [AW-1:0] ad, input logic [DW-1:0] d);
        drv(p, 1'b0, 1'b1, w, l, i, ad, d);
        step();
        idl(p);
        step();
    endtask

    function automatic logic [DW-1:0] dq(input int p);
        return (p == 0) ? a_dout : b_dout;
    endfunction

    function automatic logic vq(input int p);
        return (p == 0) ? a_dvld : b_dvld;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R10 reset state
        chk("R10 a_dvld", a_dvld, 0);
        chk("R10 b_dvld", b_dvld, 0);
        chk("R10 a_drv", a_drv, 0);
        chk("R10 b_drv", b_drv, 0);
        chk("R10 coll", coll, 0);

        // R1 exhaustive: write through A, read through B
        for (int k = 0; k < DEPTH; k++) begin
            ref_mem[k] = DW'(k * 7 + 3);
            op(0, 1'b1, 1'b1, 1'b0, AW'(k), ref_mem[k]);
        end
        for (int k = 0; k < DEPTH; k++) begin
            op(1, 1'b0, 1'b1, 1'b0, AW'(k), '0);
            chk("R1 b_dvld", b_dvld, 1);
            chk("R1 b_drv", b_drv, 1);
            chk("R1 b_dout", b_dout, ref_mem[k]);
        end

        // R3 counter-driven writes through B, read back through A
        op(1, 1'b1, 1'b1, 1'b0, '0, DW'(5));
        ref_mem[0] = DW'(5);
        for (int k = 1; k < DEPTH; k++) begin
            ref_mem[k] = DW'(k * 13 + 5);
            op(1, 1'b1, 1'b0, 1'b1, '0, ref_mem[k]);
        end
        for (int k = 0; k < DEPTH; k++) begin
            op(0, 1'b0, 1'b1, 1'b0, AW'(k), '0);
            chk("R3 counted write a_dout", a_dout, ref_mem[k]);
        end

        // R3 load, advance, wrap, hold
        op(1, 1'b0, 1'b1, 1'b0, AW'(14), '0);
        chk("R3 load", b_dout, ref_mem[14]);
        op(1, 1'b0, 1'b0, 1'b1, '0, '0);
        chk("R3 inc", b_dout, ref_mem[15]);
        op(1, 1'b0, 1'b0, 1'b1, '0, '0);
        chk("R3 wrap", b_dout, ref_mem[0]);
        op(1, 1'b0, 1'b0, 1'b0, AW'(9), '0);
        chk("R3 hold", b_dout, ref_mem[0]);
        repeat (3) step();
        op(1, 1'b0, 1'b0, 1'b1, '0, '0);
        chk("R3 idle no move", b_dout, ref_mem[1]);
        // R1 valid is a single-cycle flag
        step();
        chk("R1 dvld drops", b_dvld, 0);

        // R2 asynchronous output enable
        a_oe_n = 1'b1;
        op(0, 1'b0, 1'b1, 1'b0, AW'(3), '0);
        chk("R2 dvld with oe off", a_dvld, 1);
        chk("R2 drv off", a_drv, 0);
        a_oe_n = 1'b0;
        #1;
        chk("R2 drv on without edge", a_drv, 1);
        chk("R2 dout", a_dout, ref_mem[3]);
        step();

        // R4 power-down on A, then accesses are dropped
        drv(0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
        step();
        idl(0);
        step();
        op(0, 1'b0, 1'b1, 1'b0, AW'(5), '0);
        chk("R4 read dropped", a_dvld, 0);
        op(0, 1'b1, 1'b1, 1'b0, AW'(2), DW'(8'hAA));
        // R5 wake: two consecutive selected cycles
        drv(0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, AW'(4), '0);
        step();
        drv(0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, AW'(2), '0);
        step();
        chk("R5 first wake cycle no data", a_dvld, 0);
        idl(0);
        step();
        chk("R5 second wake cycle data", a_dvld, 1);
        chk("R4 write dropped", a_dout, ref_mem[2]);
        op(0, 1'b0, 1'b1, 1'b0, AW'(7), '0);
        chk("R5 back in run", a_dout, ref_mem[7]);

        // R6 sleep on B
        op(1, 1'b0, 1'b1, 1'b0, AW'(6), '0);
        chk("R6 pre-sleep valid", b_dvld, 1);
        b_zz = 1'b1;
        #1;
        chk("R6 async drv", b_drv, 0);
        chk("R6 async dvld", b_dvld, 0);
        drv(1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, AW'(6), DW'(8'h5A));
        repeat (4) step();
        drv(1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, AW'(6), '0);
        step();
        chk("R6 no read in sleep", b_dvld, 0);
        // R7 leave sleep: selected reads in consecutive cycles
        b_zz = 1'b0;
        step();
        step();
        chk("R7 exit cycle no data", b_dvld, 0);
        step();
        chk("R7 rearm cycle no data", b_dvld, 0);
        idl(1);
        step();
        chk("R7 read after rearm", b_dvld, 1);
        chk("R6 sleep write dropped", b_dout, ref_mem[6]);

        // R8 same-address collision
        drv(0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, AW'(9), DW'(8'h11));
        drv(1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, AW'(9), DW'(8'h22));
        step();
        idl(0); idl(1);
        step();
        chk("R8 coll pulse", coll, 1);
        step();
        chk("R8 coll one cycle", coll, 0);
        ref_mem[9] = DW'(8'h11);
        op(1, 1'b0, 1'b1, 1'b0, AW'(9), '0);
        chk("R8 port A wins", b_dout, ref_mem[9]);

        drv(0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, AW'(10), DW'(8'h33));
        drv(1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, AW'(11), DW'(8'h44));
        step();
        idl(0); idl(1);
        step();
        chk("R8 no coll different addr", coll, 0);
        ref_mem[10] = DW'(8'h33);
        ref_mem[11] = DW'(8'h44);
        op(0, 1'b0, 1'b1, 1'b0, AW'(11), '0);
        chk("R8 both stored b", a_dout, ref_mem[11]);
        op(1, 1'b0, 1'b1, 1'b0, AW'(10), '0);
        chk("R8 both stored a", b_dout, ref_mem[10]);

        // R9 read while other port writes same address
        drv(0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, AW'(12), '0);
        drv(1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, AW'(12), DW'(8'h77));
        step();
        idl(0); idl(1);
        step();
        chk("R9 old data", a_dout, ref_mem[12]);
        ref_mem[12] = DW'(8'h77);
        op(0, 1'b0, 1'b1, 1'b0, AW'(12), '0);
        chk("R9 new data after", a_dout, ref_mem[12]);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule